// File: doc/BRIEF.md
# Compensated Fixed-Width Radix-4 Booth Multiplier

This block multiplies two signed two's-complement operands of `L` bits each and returns a signed result of only `L` bits. That result is the top half of the product. The multiplier operand is recoded into radix-4 Booth digits, so the design builds `L/2` partial-product rows instead of `L`.

Not every bit of those rows is added. The adder takes every row bit that falls in the kept upper half. It also takes the bits in the `W` columns just below that half. All row bits further down are discarded. To make up for the carries those discarded bits would have produced, the adder adds a compensation term. This term is half of the nonzero-digit count, scaled to the weight of the lowest retained column. Raising `W` improves accuracy at the cost of a wider adder.

Operands enter through a valid/ready handshake and leave through a single output register with its own valid/ready handshake. A pair is accepted whenever the output register is empty or its content is being taken in the same cycle. While the consumer holds `out_ready` low with a result pending, `in_ready` is low and the result is held unchanged. The parameters must satisfy: `L` even and between 8 and 16, and `W` between 0 and `L-1`.

Top module: `fwb_mult`

## Requirements
- R1: While `rst_n` is low and in the first cycle after reset, `out_valid` is 0 and `in_ready` is 1.
- R2: For every operand pair, the signed result differs from floor(a*b / 2^L) by at most ceil((L/2) / 2^W). With the defaults L=8 and W=2, the allowed error is 1.
- R3: Each Booth digit comes from the 3-bit group {b[2j+1], b[2j], b[2j-1]}, with b[-1]=0. A group of 000 or 111 is a zero digit and contributes nothing, so a multiplier of 0 yields a result of exactly 0 for any multiplicand.
- R4: The compensation adds (number of nonzero digits) x 2^(L-W-1) before the top L bits are taken. Over all operand pairs, the mean signed error against floor(a*b / 2^L) lies within +/- 1/4.
- R5: A pair presented with `in_valid` and `in_ready` both high produces `out_valid` high in the next cycle, carrying that pair's result.
- R6: While `out_valid` is 1 and `out_ready` is 0, `out_valid` and `out_prod` stay unchanged.
- R7: `in_ready` is 0 exactly when a result is pending and `out_ready` is 0. Otherwise it is 1, including the cycle in which a pending result is taken.
- R8: When a pending result is taken and no new pair is offered, `out_valid` is 0 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operand pair present |
| in_ready | output | 1 | Block can accept a pair this cycle |
| in_a | input | L | Multiplicand, signed |
| in_b | input | L | Multiplier, signed, Booth recoded |
| out_valid | output | 1 | Result register holds a result |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_prod | output | L | Compensated upper half of the product, signed |

## Verification
Two events can fall in the same cycle: a pending result leaves the register while a new operand pair enters it. The bench provokes this in two ways. It holds a result stalled, keeps a different pair waiting, and then raises `out_ready`. It also streams every operand pair back to back with `out_ready` held high. The overlap is judged correct when `out_valid` stays high with no bubble and `out_prod` changes in that very cycle from the held value to a value within the R2 bound of the new pair's product.

// File: rtl/fwb_pkg.sv
package fwb_pkg;

  // One radix-4 Booth digit: nonzero flag, negative sign, magnitude two
  typedef struct packed {
    logic nz;
    logic neg;
    logic dbl;
  } bdig_t;

  // Recode a 3-bit overlapping group {b[2j+1], b[2j], b[2j-1]}
  function automatic bdig_t recode(input logic [2:0] g);
    bdig_t d;
    d.nz  = !(g == 3'b000 || g == 3'b111);
    d.neg = g[2] & ~(g[1] & g[0]);
    d.dbl = (g == 3'b011) || (g == 3'b100);
    return d;
  endfunction

endpackage

// File: rtl/fwb_booth_enc.sv
module fwb_booth_enc
  import fwb_pkg::*;
#(
  parameter int L = 8
) (
  input  logic [L-1:0]            mult,
  output bdig_t [L/2-1:0]         dig
);
  localparam int NR = L / 2;

  // Multiplier with an implicit zero below bit 0
  logic [L:0] ext;
  assign ext = {mult, 1'b0};

  for (genvar j = 0; j < NR; j++) begin : g_grp
    assign dig[j] = recode(ext[2*j+2 : 2*j]);
  end

endmodule

// File: rtl/fwb_row_sum.sv
module fwb_row_sum
  import fwb_pkg::*;
#(
  parameter int L = 8,
  parameter int W = 2
) (
  input  logic [L-1:0]    mcand,
  input  bdig_t [L/2-1:0] dig,
  output logic [L-1:0]    prod
);
  localparam int NR = L / 2;
  localparam int PW = 2 * L;
  localparam int LO = L - W;               // lowest column that is summed
  localparam int CW = $clog2(NR + 1);
  localparam logic [PW-1:0] KEEP = {PW{1'b1}} << LO;

  // Truncated, sign-extended rows
  logic [PW-1:0] row [NR];

  for (genvar j = 0; j < NR; j++) begin : g_row
    localparam int SH = 2 * j;
    logic [L:0]    mag;
    logic [L:0]    pick;
    logic [PW-1:0] wide;
    logic [PW-1:0] fix;

    assign mag  = dig[j].dbl ? {mcand, 1'b0} : {mcand[L-1], mcand};
    assign pick = !dig[j].nz ? '0 : (dig[j].neg ? ~mag : mag);
    assign wide = {{(PW-L-1){pick[L]}}, pick};

    // The +1 of a negated row survives only if it lands in a summed column
    if (SH >= LO) begin : g_fix_kept
      assign fix = dig[j].neg ? (PW'(1) << SH) : '0;
    end else begin : g_fix_dropped
      assign fix = '0;
    end

    assign row[j] = ((wide << SH) & KEEP) + fix;
  end

  // Population count of nonzero digits drives the carry estimate
  logic [CW-1:0] nzc;
  always_comb begin
    nzc = '0;
    for (int j = 0; j < NR; j++) nzc = nzc + CW'(dig[j].nz);
  end

  logic [PW-1:0] comp;
  assign comp = PW'(nzc) << (LO - 1);

  logic [PW-1:0] total;
  always_comb begin
    total = comp;
    for (int j = 0; j < NR; j++) total = total + row[j];
  end

  assign prod = total[PW-1:L];

endmodule

// File: rtl/fwb_mult.sv
module fwb_mult
  import fwb_pkg::*;
#(
  parameter int L = 8,
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [L-1:0] in_a,
  input  logic [L-1:0] in_b,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [L-1:0] out_prod
);
  localparam int NR = L / 2;

  bdig_t [NR-1:0] dig;
  logic  [L-1:0]  res;

  fwb_booth_enc #(.L(L)) u_enc (
    .mult (in_b),
    .dig  (dig)
  );

  fwb_row_sum #(.L(L), .W(W)) u_sum (
    .mcand (in_a),
    .dig   (dig),
    .prod  (res)
  );

  // Single output register, accepts when empty or being drained
  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_prod  <= '0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) out_prod <= res;
    end
  end

  // R5
  accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid);

  // R6
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_prod));

  // R8
  drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && !in_valid |=> !out_valid);

  // R3
  zero_mult_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && (in_b == '0) |=> out_prod == '0);

endmodule

// File: tb/fwb_mult_bench.sv
`timescale 1ns/1ps
module fwb_mult_bench;
  localparam int L = 8;
  localparam int W = 2;
  localparam int BOUND = (L/2 + (1 << W) - 1) >> W;
  localparam int LOV = -(1 << (L-1));
  localparam int HIV = (1 << (L-1)) - 1;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [L-1:0] in_a = '0;
  logic [L-1:0] in_b = '0;
  logic         out_valid;
  logic         out_ready = 1'b0;
  logic [L-1:0] out_prod;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;   // 125 MHz

  fwb_mult #(.L(L), .W(W)) u_fwb_mult (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_a(in_a), .in_b(in_b), .out_valid(out_valid),
    .out_ready(out_ready), .out_prod(out_prod)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int sprod();
    return int'($signed(out_prod));
  endfunction

  function automatic int ref_of(input int a, input int b);
    return (a * b) >>> L;
  endfunction

  function automatic int absi(input int v);
    return (v < 0) ? -v : v;
  endfunction

  task automatic t_reset;
    #1;
    chk(out_valid == 1'b0, "R1 out_valid in reset", int'(out_valid), 0);
    chk(in_ready == 1'b1, "R1 in_ready in reset", int'(in_ready), 1);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    chk(out_valid == 1'b0, "R1 out_valid after reset", int'(out_valid), 0);
    chk(in_ready == 1'b1, "R7 in_ready idle", int'(in_ready), 1);
  endtask

  task automatic t_zero_mult;
    int avals [6] = '{0, 1, -1, HIV, LOV, 85};
    out_ready = 1'b1;
    foreach (avals[i]) begin
      @(negedge clk);
      in_valid = 1'b1; in_a = L'(avals[i]); in_b = '0;
      @(negedge clk);
      in_valid = 1'b0;
      chk(out_valid == 1'b1, "R5 valid after zero-mult accept", int'(out_valid), 1);
      chk(out_prod == '0, "R3 zero multiplier gives zero", sprod(), 0);
    end
    @(negedge clk);
  endtask

  task automatic t_stall_overlap;
    int held;
    int e2;
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b1; in_a = L'(3); in_b = '0;
    @(negedge clk);
    chk(out_valid == 1'b1, "R5 first result valid", int'(out_valid), 1);
    held = sprod();
    out_ready = 1'b0;
    in_a = L'(LOV); in_b = L'(LOV);
    #1;
    chk(in_ready == 1'b0, "R7 in_ready low while stalled", int'(in_ready), 0);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk(out_valid == 1'b1, "R6 valid held in stall", int'(out_valid), 1);
      chk(sprod() == held, "R6 result held in stall", sprod(), held);
      chk(in_ready == 1'b0, "R7 in_ready stays low", int'(in_ready), 0);
    end
    out_ready = 1'b1;
    #1;
    chk(in_ready == 1'b1, "R7 in_ready high while draining", int'(in_ready), 1);
    @(negedge clk);
    in_valid = 1'b0;
    e2 = ref_of(LOV, LOV);
    chk(out_valid == 1'b1, "R5 overlap keeps valid", int'(out_valid), 1);
    chk(absi(sprod() - e2) <= BOUND, "R5 overlap takes new pair", sprod(), e2);
    @(negedge clk);
    chk(out_valid == 1'b0, "R8 drain clears valid", int'(out_valid), 0);
    chk(in_ready == 1'b1, "R7 in_ready after drain", int'(in_ready), 1);
  endtask

  task automatic t_exhaustive;
    int pa = 0, pb = 0;
    bit have = 0;
    longint sum_err = 0;
    int cnt = 0;
    int max_err = 0;
    out_ready = 1'b1;
    for (int ai = LOV; ai <= HIV; ai++) begin
      for (int bi = LOV; bi <= HIV; bi++) begin
        @(negedge clk);
        if (have) begin
          int e = sprod() - ref_of(pa, pb);
          chk(out_valid == 1'b1, "R5 streamed result valid", int'(out_valid), 1);
          chk(absi(e) <= BOUND, "R2 error bound", sprod(), ref_of(pa, pb));
          sum_err += e; cnt++;
          if (absi(e) > max_err) max_err = absi(e);
        end
        in_valid = 1'b1; in_a = L'(ai); in_b = L'(bi);
        pa = ai; pb = bi; have = 1;
      end
    end
    @(negedge clk);
    begin
      int e = sprod() - ref_of(pa, pb);
      chk(absi(e) <= BOUND, "R2 error bound last pair", sprod(), ref_of(pa, pb));
      sum_err += e; cnt++;
    end
    in_valid = 1'b0;
    // R4: mean signed error within a quarter of one output unit
    chk(4 * (sum_err < 0 ? -sum_err : sum_err) <= longint'(cnt),
        "R4 mean bias x4 vs count", int'(4 * sum_err), cnt);
    chk(max_err <= BOUND, "R2 max error", max_err, BOUND);
    @(negedge clk);
    chk(out_valid == 1'b0, "R8 idle after stream", int'(out_valid), 0);
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_zero_mult();
    t_stall_overlap();
    t_exhaustive();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule